// File: doc/BRIEF.md
# Peripheral Clock-Enable Divider Chain

This block derives one peripheral clock enable from four shared reference enable streams. Everything runs on a single fast system clock. Each reference arrives as a train of one-cycle enable pulses, and the block passes a chosen fraction of one stream to the peripheral as its clock enable. A source selector picks one stream. Two cascaded integer dividers, each programmed by its own 3-bit code, thin that stream. A disable gate then either passes or blocks the result.

Software programs the chain through a small write-only register port. The block also drives a combinational view of the total division ratio, so the integration layer can report the effective rate. When either divide code is out of range, the output stops. Any write that reprograms the source or a divider restarts both divide counters, so no shortened period is emitted.

Top module: `perclk_chain`

## Requirements
- R1: After reset the gate is disabled (disable bit = 1), the source select is 0 and both divide codes are 1. `divRatio` reads 1 and `clkEnOut` stays low until the gate is enabled.
- R2: The source select (write offset 0x00, data bits [1:0]) picks which `refEn` bit is counted. Pulses on the other three bits have no effect on `clkEnOut`.
- R3: Divide codes 1 to 6 divide by that value. The first stage is at offset 0x04 and the second at offset 0x08, each taking data bits [2:0]. `divRatio` equals the first value times the second.
- R4: `clkEnOut` gives one pulse, one system clock wide, for every N selected reference pulses, where N is `divRatio`. The pulse appears in the cycle after the clock edge that samples the Nth selected pulse.
- R5: A divide code of 0 or 7 in either stage is invalid. It makes `divRatio` read 0, holds both counters at zero, and produces no output pulses.
- R6: The disable bit is at offset 0x14, data bit 0. Writing 1 blocks `clkEnOut` and holds both counters at zero. Writing 0 enables the gate, and counting then starts from zero.
- R7: Any write to offset 0x00, 0x04 or 0x08 clears both divide counters at that clock edge. A reference pulse in that same cycle is not counted.
- R8: Writes to any other offset, including 0x0C and 0x10, change neither `divRatio` nor the pulse sequence on `clkEnOut`.
- R9: `divRatio` never exceeds 36, the product of the two largest valid codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refEn | input | 4 | One enable stream per reference source |
| cfgWr | input | 1 | Register write strobe |
| cfgAddr | input | 5 | Register byte offset |
| cfgWrData | input | 8 | Register write data |
| clkEnOut | output | 1 | Gated, divided peripheral clock enable |
| divRatio | output | 6 | Effective total division ratio, 0 when a code is invalid |

## Verification
The bench builds the block with its default parameters: four sources, 3-bit divide codes with a valid range of 1 to 6, a 5-bit offset and an 8-bit data bus. Under these values every code pair can be reached, including both invalid codes and the largest ratio of 36. The bench writes random codes, so reprogramming happens in the middle of a count and often lands in the same cycle as a reference pulse. Directed runs cover the source mask, the gate, writes to unmapped offsets and back-to-back pulses at ratio 1.

// File: rtl/perclk_pkg.sv
package perclk_pkg;

  localparam int NUM_SRC  = 4;
  localparam int SEL_W    = $clog2(NUM_SRC);
  localparam int CODE_W   = 3;
  localparam int MAX_CODE = 6;
  localparam int RATIO_W  = 2 * CODE_W;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 8;

  localparam logic [ADDR_W-1:0] OFS_SRC  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_DIVA = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_DIVB = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_GATE = 5'h14;

  typedef struct packed {
    logic [SEL_W-1:0]  srcSel;
    logic [CODE_W-1:0] divA;
    logic [CODE_W-1:0] divB;
    logic              restart;
    logic              gateOff;
    logic              codesOk;
  } chainCtl_t;

  function automatic logic codeValid(input logic [CODE_W-1:0] code);
    return (code != '0) && (int'(code) <= MAX_CODE);
  endfunction

endpackage

// File: rtl/perclk_ctrl.sv
module perclk_ctrl
  import perclk_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfgWr,
  input  logic [ADDR_W-1:0]   cfgAddr,
  input  logic [DATA_W-1:0]   cfgWrData,
  output chainCtl_t           ctl,
  output logic [RATIO_W-1:0]  divRatio
);

  logic [SEL_W-1:0]  srcReg;
  logic [CODE_W-1:0] divAReg;
  logic [CODE_W-1:0] divBReg;
  logic              gateOffReg;
  logic hitSrc, hitDivA, hitDivB, hitGate;

  always_comb begin
    hitSrc  = cfgWr && (cfgAddr == OFS_SRC);
    hitDivA = cfgWr && (cfgAddr == OFS_DIVA);
    hitDivB = cfgWr && (cfgAddr == OFS_DIVB);
    hitGate = cfgWr && (cfgAddr == OFS_GATE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      srcReg     <= '0;
      divAReg    <= CODE_W'(1);
      divBReg    <= CODE_W'(1);
      gateOffReg <= 1'b1;
    end else begin
      if (hitSrc)  srcReg     <= cfgWrData[SEL_W-1:0];
      if (hitDivA) divAReg    <= cfgWrData[CODE_W-1:0];
      if (hitDivB) divBReg    <= cfgWrData[CODE_W-1:0];
      if (hitGate) gateOffReg <= cfgWrData[0];
    end
  end

  always_comb begin
    ctl.srcSel  = srcReg;
    ctl.divA    = divAReg;
    ctl.divB    = divBReg;
    ctl.restart = hitSrc || hitDivA || hitDivB;
    ctl.gateOff = gateOffReg;
    ctl.codesOk = codeValid(divAReg) && codeValid(divBReg);
    divRatio    = ctl.codesOk ? (RATIO_W'(divAReg) * RATIO_W'(divBReg)) : '0;
  end

  // R9
  ratio_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(divRatio) <= MAX_CODE * MAX_CODE);

  // R8
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgWr && !hitSrc && !hitDivA && !hitDivB && !hitGate) |=> $stable(divRatio));

endmodule

// File: rtl/perclk_divstage.sv
module perclk_divstage
  import perclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              tickIn,
  input  logic [CODE_W-1:0] divVal,
  output logic              tickOut
);

  logic [CODE_W-1:0] cnt;
  logic              atTop;

  always_comb begin
    atTop   = (cnt == (divVal - CODE_W'(1)));
    tickOut = tickIn && atTop;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear)  cnt <= '0;
    else if (tickIn)      cnt <= atTop ? '0 : cnt + CODE_W'(1);
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) < MAX_CODE);

endmodule

// File: rtl/perclk_datapath.sv
module perclk_datapath
  import perclk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] refEn,
  input  chainCtl_t          ctl,
  output logic               clkEnOut
);

  localparam int STAGES = 2;

  logic              tick [STAGES+1];
  logic [CODE_W-1:0] stageDiv [STAGES];
  logic              holdClear;

  always_comb begin
    tick[0]     = refEn[ctl.srcSel];
    stageDiv[0] = ctl.divA;
    stageDiv[1] = ctl.divB;
    holdClear   = ctl.restart || ctl.gateOff || !ctl.codesOk;
  end

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    perclk_divstage u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (holdClear),
      .tickIn  (tick[g]),
      .divVal  (stageDiv[g]),
      .tickOut (tick[g+1])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) clkEnOut <= 1'b0;
    else        clkEnOut <= tick[STAGES] && !holdClear;
  end

  // R6
  gate_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.gateOff |=> !clkEnOut);

  // R5
  invalid_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.codesOk |=> !clkEnOut);

  // R7
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.restart |=> !clkEnOut);

  // R4
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clkEnOut && (ctl.divA != CODE_W'(1) || ctl.divB != CODE_W'(1))) |=> !clkEnOut);

endmodule

// File: rtl/perclk_chain.sv
module perclk_chain
  import perclk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] refEn,
  input  logic               cfgWr,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [DATA_W-1:0]  cfgWrData,
  output logic               clkEnOut,
  output logic [RATIO_W-1:0] divRatio
);

  chainCtl_t ctl;

  perclk_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfgWr     (cfgWr),
    .cfgAddr   (cfgAddr),
    .cfgWrData (cfgWrData),
    .ctl       (ctl),
    .divRatio  (divRatio)
  );

  perclk_datapath u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .refEn    (refEn),
    .ctl      (ctl),
    .clkEnOut (clkEnOut)
  );

endmodule

// File: tb/perclk_chain_bench.sv
module perclk_chain_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] refEn = '0;
  logic       cfgWr = 1'b0;
  logic [4:0] cfgAddr = '0;
  logic [7:0] cfgWrData = '0;
  logic       clkEnOut;
  logic [5:0] divRatio;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  int mSrc = 0, mDa = 1, mDb = 1, mDis = 1, c1 = 0, c2 = 0;
  bit expOut = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  perclk_chain u_perclk_chain (
    .clk(clk), .rst_n(rst_n), .refEn(refEn), .cfgWr(cfgWr),
    .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .clkEnOut(clkEnOut), .divRatio(divRatio)
  );

  function automatic bit okCode(int c);
    return c >= 1 && c <= 6;
  endfunction

  function automatic int expRatio();
    return (okCode(mDa) && okCode(mDb)) ? mDa * mDb : 0;
  endfunction

  task automatic check(string tag);
    checks++;
    if (clkEnOut !== expOut || int'(divRatio) != expRatio()) begin
      fails++;
      $display("FAIL %s: clkEnOut=%0b divRatio=%0d expected clkEnOut=%0b divRatio=%0d",
               tag, clkEnOut, divRatio, expOut, expRatio());
    end
  endtask

  // drive one cycle, advance model, check after the edge
  task automatic step(input logic [3:0] r, input bit wr, input logic [4:0] a,
                      input logic [7:0] d, input string tag);
    bit restart, clr, sel, t1, t2;
    refEn = r; cfgWr = wr; cfgAddr = a; cfgWrData = d;
    restart = wr && (a == 5'h00 || a == 5'h04 || a == 5'h08);
    clr = restart || mDis == 1 || !(okCode(mDa) && okCode(mDb));
    sel = r[mSrc];
    t1 = sel && (c1 == mDa - 1);
    t2 = t1 && (c2 == mDb - 1);
    expOut = !clr && t2;
    if (clr) begin c1 = 0; c2 = 0; end
    else begin
      if (sel) c1 = t1 ? 0 : c1 + 1;
      if (t1)  c2 = t2 ? 0 : c2 + 1;
    end
    if (wr) begin
      case (a)
        5'h00: mSrc = int'(d[1:0]);
        5'h04: mDa  = int'(d[2:0]);
        5'h08: mDb  = int'(d[2:0]);
        5'h14: mDis = int'(d[0]);
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    cfgWr = 1'b0;
    check(tag);
  endtask

  task automatic idle(int n, logic [3:0] r, string tag);
    for (int i = 0; i < n; i++) step(r, 0, 5'h00, 8'h00, tag);
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d, logic [3:0] r, string tag);
    step(r, 1, a, d, tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int pulses;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1");                          // reset state
    idle(6, 4'hF, "R1");                  // gate still closed after reset

    wr(5'h14, 8'h00, 4'h0, "R6");         // open gate
    wr(5'h00, 8'h02, 4'h0, "R2");
    wr(5'h04, 8'h02, 4'h0, "R3");
    wr(5'h08, 8'h03, 4'h0, "R3");
    pulses = 0;
    for (int i = 0; i < 60; i++) begin
      step(4'b0100, 0, 5'h00, 8'h00, "R4");
      if (clkEnOut) pulses++;
    end
    checks++;                             // R4: 60 pulses / ratio 6 = 10
    if (pulses != 10) begin
      fails++;
      $display("FAIL R4: pulse count=%0d expected=10", pulses);
    end
    idle(30, 4'b1011, "R2");              // unselected sources only

    wr(5'h04, 8'h07, 4'hF, "R5");
    idle(15, 4'hF, "R5");
    wr(5'h04, 8'h00, 4'hF, "R5");
    idle(15, 4'hF, "R5");
    wr(5'h04, 8'h01, 4'hF, "R3");
    idle(4, 4'b0100, "R3");

    wr(5'h00, 8'h02, 4'b0100, "R7");      // restart with pulse in same cycle
    idle(8, 4'b0100, "R7");
    wr(5'h08, 8'h03, 4'b0100, "R7");
    idle(8, 4'b0100, "R7");

    wr(5'h0C, 8'hFF, 4'b0100, "R8");
    idle(3, 4'b0100, "R8");
    wr(5'h10, 8'hA5, 4'b0100, "R8");
    idle(3, 4'b0100, "R8");
    wr(5'h18, 8'h07, 4'b0100, "R8");
    idle(5, 4'b0100, "R8");

    wr(5'h14, 8'h01, 4'hF, "R6");
    idle(10, 4'hF, "R6");
    wr(5'h14, 8'h00, 4'hF, "R6");
    idle(10, 4'hF, "R6");

    wr(5'h04, 8'h06, 4'h0, "R9");
    wr(5'h08, 8'h06, 4'h0, "R9");
    idle(80, 4'b0100, "R9");
    wr(5'h04, 8'h01, 4'h0, "R4");
    wr(5'h08, 8'h01, 4'h0, "R4");
    idle(6, 4'b0100, "R4");               // ratio 1: continuous enable

    for (int i = 0; i < 4000; i++) begin
      logic [3:0] r;
      logic [4:0] a;
      logic [7:0] d;
      r = 4'($urandom);
      if ($urandom_range(15) == 0) begin
        case ($urandom_range(6))
          0: a = 5'h00;
          1: a = 5'h04;
          2: a = 5'h08;
          3: a = 5'h14;
          4: a = 5'h0C;
          5: a = 5'h10;
          default: a = 5'($urandom);
        endcase
        d = 8'($urandom);
        if (a == 5'h14 && $urandom_range(3) != 0) d[0] = 1'b0;
        if ((a == 5'h04 || a == 5'h08) && $urandom_range(3) != 0)
          d[2:0] = 3'($urandom_range(6, 1));
        step(r, 1, a, d, "R4");
      end else begin
        step(r, 0, 5'h00, 8'h00, "R4");
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule